// File: doc/BRIEF.md
# Flash Control Register Unlock Guard

This block sits between a simple register bus and the control register of a flash erase/program engine. The control register comes out of reset write-protected. Software opens it by writing two fixed 32-bit key words, in a fixed order, to a dedicated key register. Any deviation from that sequence bars the control register until the next reset.

Once open, software writes the control field that drives the engine. It closes the register again by writing a 1 to the lock bit. While the engine reports busy, any control-register write is held on the bus with ready low. The write completes in the first cycle that busy is low.

The bus is valid/ready. A transfer completes on a rising clock edge where `bus_valid` and `bus_ready` are both high. The master must hold address, direction and data stable while `bus_ready` is low. Only control-register writes made while `busy` is high apply back-pressure. Every other access completes in the cycle it is presented.

Top module: `keyguard_top`

## Requirements
- R1: After reset the control read-back (word address 1) shows the lock bit (bit 31) at 1, the control field (bits CTRL_W-1:0) at 0, and `lockout` is 0.
- R2: While locked, a control-register write leaves the control field and `ctrl_q` unchanged.
- R3: A key-register write (word address 0) of 0x45670123 followed by a key-register write of 0xCDEF89AB clears the lock bit. After that, control-register writes load bits CTRL_W-1:0 into `ctrl_q`.
- R4: A first key write with any value other than 0x45670123 raises `lockout`. The register then stays locked, even after a correct key pair, until reset.
- R5: A second key write other than 0xCDEF89AB raises `lockout`. So does 0xCDEF89AB written without a preceding 0x45670123.
- R6: The key register always reads as zero. A key write while unlocked changes neither the lock bit nor `lockout`.
- R7: A control write with bit 31 set, made while unlocked, relocks the register after loading its control field. Later control writes are ignored, and a fresh correct key pair unlocks it again.
- R8: A control-register write presented while `busy` is high holds `bus_ready` low and leaves `ctrl_q` unchanged. It completes in the first cycle `busy` is low.
- R9: A relock write presented while `busy` is high takes effect only after `busy` drops. Until then the lock bit still reads 0.
- R10: Reads and key writes complete with `bus_ready` high in the cycle they are presented, regardless of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (0 key, 1 control) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Transfer completes when high with valid |
| bus_rdata | output | 32 | Read data, valid with the request |
| busy | input | 1 | Flash engine busy |
| ctrl_q | output | CTRL_W | Control field to the flash engine |
| lockout | output | 1 | Key sequence error lockout flag |

## Verification
The hardest situation to reach is a relock write that is stalled by `busy` while the register is still open. It needs a full correct key pair, then `busy` raised before a write with bit 31 set is presented. The stimulus holds that write for several cycles. It reads nothing else during the stall, then checks that `ctrl_q` is frozen and `bus_ready` stays low. It then drops `busy` and confirms the lock bit only now reads 1. The lockout cases are reached by resetting between scenarios and deliberately feeding wrong or out-of-order key words.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB;
  localparam int unsigned LOCK_BIT = 31;

  typedef enum logic [1:0] {
    SEQ_LOCKED = 2'd0,
    SEQ_HALF   = 2'd1,
    SEQ_OPEN   = 2'd2,
    SEQ_BARRED = 2'd3
  } seq_state_e;
endpackage

// File: rtl/guard_bus_decode.sv
module guard_bus_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = '0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              busy,
  output logic              bus_ready,
  output logic              key_wr,
  output logic              ctrl_wr,
  output logic              sel_ctrl
);
  logic hit_key, hit_ctrl, ctrl_wr_req;

  always_comb begin
    hit_key     = (bus_addr == KEY_ADDR);
    hit_ctrl    = (bus_addr == CTRL_ADDR);
    ctrl_wr_req = bus_valid && bus_write && hit_ctrl;
    // only control writes are held back by the engine
    bus_ready   = !(ctrl_wr_req && busy);
    key_wr      = bus_valid && bus_write && hit_key;
    ctrl_wr     = ctrl_wr_req && !busy;
    sel_ctrl    = hit_ctrl;
  end
endmodule

// File: rtl/guard_key_seq.sv
module guard_key_seq
  import keyguard_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIRST  = KEY_FIRST,
  parameter logic [DATA_W-1:0] SECOND = KEY_SECOND
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              relock,
  output logic              unlocked,
  output logic              lockout
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_LOCKED: if (key_wr) state_d = (key_data == FIRST)  ? SEQ_HALF : SEQ_BARRED;
      SEQ_HALF:   if (key_wr) state_d = (key_data == SECOND) ? SEQ_OPEN : SEQ_BARRED;
      SEQ_OPEN:   if (relock) state_d = SEQ_LOCKED;
      SEQ_BARRED: state_d = SEQ_BARRED;
      default:    state_d = SEQ_BARRED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == SEQ_OPEN);
  assign lockout  = (state_q == SEQ_BARRED);

  // lockout persists until reset
  assert_lockout_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> lockout);
  // opening only directly after the second key word
  assert_open_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !unlocked && key_data != SECOND) |=> !unlocked);
  // key writes never disturb an open register
  assert_key_ignored_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr) |=> (unlocked && !lockout));
endmodule

// File: rtl/guard_ctrl_reg.sv
module guard_ctrl_reg #(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] wr_field,
  input  logic              wr_lock,
  input  logic              unlocked,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              relock
);
  logic take;

  assign take   = ctrl_wr && unlocked;
  assign relock = take && wr_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= '0;
    else if (take) ctrl_q <= wr_field;
  end

  // protected register holds its value
  assert_locked_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ctrl_q));
endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
  import keyguard_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              lockout
);
  localparam int unsigned PAD_W = DATA_W - 1 - CTRL_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 1;

  logic key_wr, ctrl_wr, sel_ctrl, unlocked, relock;

  guard_bus_decode #(.ADDR_W(ADDR_W), .KEY_ADDR('0), .CTRL_ADDR(CTRL_ADDR)) u_decode (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .busy(busy),
    .bus_ready(bus_ready), .key_wr(key_wr), .ctrl_wr(ctrl_wr), .sel_ctrl(sel_ctrl)
  );

  guard_key_seq u_seq (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata),
    .relock(relock), .unlocked(unlocked), .lockout(lockout)
  );

  guard_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_field(bus_wdata[CTRL_W-1:0]),
    .wr_lock(bus_wdata[LOCK_BIT]), .unlocked(unlocked), .ctrl_q(ctrl_q), .relock(relock)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb bus_rdata = sel_ctrl ? {!unlocked, {PAD_W{1'b0}}, ctrl_q} : '0;
    end else begin : g_nopad
      always_comb bus_rdata = sel_ctrl ? {!unlocked, ctrl_q} : '0;
    end
  endgenerate

  // a stalled control write changes nothing
  assert_stall_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == CTRL_ADDR && busy) |=> $stable(ctrl_q));
  // relock stalled by busy keeps the register open
  assert_relock_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && busy) |=> (unlocked || !$past(busy) || $past(key_wr)));
endmodule

// File: tb/test_keyguard_top.sv
module test_keyguard_top;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CTRL_W = 16;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, busy = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, lockout;
  logic [31:0] bus_rdata;
  logic [CTRL_W-1:0] ctrl_q;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyguard_top #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) i_keyguard_top (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .busy(busy), .ctrl_q(ctrl_q), .lockout(lockout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // single-cycle write, ready expected high at once
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    #1 check(req, {31'b0, bus_ready}, 32'd1);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(1, v);
    check("R1 ctrl readback", v, 32'h8000_0000);
    check("R1 lockout", {31'b0, lockout}, 0);
    check("R1 ctrl_q", {16'b0, ctrl_q}, 0);
  endtask

  task automatic t_locked_write();
    do_reset();
    wr(1, 32'h0000_1234, "R2 ready");
    check("R2 ctrl_q unchanged", {16'b0, ctrl_q}, 0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    do_reset();
    wr(0, K1, "R10 key ready"); wr(0, K2, "R10 key ready");
    rd(1, v);
    check("R3 lock cleared", v, 0);
    wr(1, 32'h0000_A5C3, "R3 ready");
    check("R3 ctrl_q loaded", {16'b0, ctrl_q}, 32'hA5C3);
    wr(0, 32'h1111_2222, "R6 ready");
    rd(1, v);
    check("R6 still open", v, 32'h0000_A5C3);
    check("R6 no lockout", {31'b0, lockout}, 0);
    rd(0, v);
    check("R6 key reads zero", v, 0);
  endtask

  task automatic t_bad_first();
    logic [31:0] v;
    do_reset();
    wr(0, 32'h4567_0124, "R4 ready");
    check("R4 lockout", {31'b0, lockout}, 1);
    wr(0, K1, "R4 ready"); wr(0, K2, "R4 ready");
    wr(1, 32'h0000_00FF, "R4 ready");
    rd(1, v);
    check("R4 stays locked", v, 32'h8000_0000);
    check("R4 lockout held", {31'b0, lockout}, 1);
    do_reset();
    check("R4 reset clears lockout", {31'b0, lockout}, 0);
  endtask

  task automatic t_bad_second();
    logic [31:0] v;
    do_reset();
    wr(0, K1, "R5 ready"); wr(0, K1, "R5 ready");
    check("R5 wrong second", {31'b0, lockout}, 1);
    do_reset();
    wr(0, K2, "R5 ready");
    check("R5 second alone", {31'b0, lockout}, 1);
    wr(0, K1, "R5 ready"); wr(0, K2, "R5 ready");
    rd(1, v);
    check("R5 still locked", v, 32'h8000_0000);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    do_reset();
    wr(0, K1, "R7 ready"); wr(0, K2, "R7 ready");
    wr(1, 32'h8000_0042, "R7 ready");
    rd(1, v);
    check("R7 relocked", v, 32'h8000_0042);
    wr(1, 32'h0000_0007, "R7 ready");
    check("R7 ignored after relock", {16'b0, ctrl_q}, 32'h42);
    wr(0, K1, "R7 ready"); wr(0, K2, "R7 ready");
    rd(1, v);
    check("R7 reopened", v, 32'h0000_0042);
  endtask

  task automatic t_busy_write(input bit relock_wr);
    logic [31:0] v;
    do_reset();
    wr(0, K1, "R8 ready"); wr(0, K2, "R8 ready");
    busy = 1'b1;
    rd(1, v);
    check("R10 read while busy", v, 0);
    wr(0, 32'h0, "R10 key write while busy");
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 1;
    bus_wdata = relock_wr ? 32'h8000_0BEE : 32'h0000_0BEE;
    for (int i = 0; i < 4; i++) begin
      #1;
      check(relock_wr ? "R9 ready low" : "R8 ready low", {31'b0, bus_ready}, 0);
      check(relock_wr ? "R9 ctrl frozen" : "R8 ctrl frozen", {16'b0, ctrl_q}, 0);
      @(negedge clk);
    end
    busy = 1'b0;
    #1 check(relock_wr ? "R9 ready after busy" : "R8 ready after busy",
             {31'b0, bus_ready}, 1);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    #1;
    check(relock_wr ? "R9 field loaded" : "R8 completed", {16'b0, ctrl_q}, 32'h0BEE);
    rd(1, v);
    check(relock_wr ? "R9 lock after busy" : "R8 still open", v,
          relock_wr ? 32'h8000_0BEE : 32'h0000_0BEE);
  endtask

  initial begin
    bus_addr = '0;
    t_reset();
    t_locked_write();
    t_unlock();
    t_bad_first();
    t_bad_second();
    t_relock();
    t_busy_write(1'b0);
    t_busy_write(1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule